// File: doc/BRIEF.md
# Three-Wire ADC Conversion Sequencer

This block sits on the host side of a small serial analog-to-digital converter. The converter has a conversion-start line, a serial clock input and a serial data output. On a single start request the sequencer encodes the requested input selection as a pulse pattern on the start line. One pulse picks the primary input, or unipolar mode. A high-low-high pattern picks the alternate input, or bipolar mode. The sequencer then keeps the line high for the acquisition window and drops it so the converter samples. It waits out the conversion time and clocks the serial word in with the clock idling low, taking each data bit on a rising clock edge.

The frame holds a 10-bit result sent MSB first and then two sub-bits. The readout always runs to its full length. A converter that is started again with part of a word still unread falls back to the alternate selection, so cutting the read short would change the next conversion's mode. The read is either one 16-clock burst or two 8-clock bursts with a gap between them. Bits after the sub-bits are thrown away. The result comes back with a one-cycle valid strobe. A widened copy is also returned: it is sign-extended when the alternate (bipolar) selection was used, and zero-extended otherwise. Every timing value is a parameter counted in system-clock cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, cnv_o, sclk_o, busy_o and done_o are 0 and data_o, sub_o, data_ext_o are 0.
- R2: A request with alt_i=0 produces exactly one rising edge on cnv_o, and cnv_o then stays high for exactly T_ACQ cycles.
- R3: A request with alt_i=1 drives cnv_o high for T_PHASE cycles, then low for T_PHASE cycles, then high for exactly T_ACQ cycles (two rising edges in total).
- R4: After the final fall of cnv_o, at least T_CONV cycles pass before the first rising edge of sclk_o, and cnv_o stays low while sclk_o is high.
- R5: Each conversion has exactly READ_CLKS (16) rising edges of sclk_o. Each high phase and each low phase lasts at least T_SCLK_HALF cycles. sclk_o is low whenever the block is idle.
- R6: sdo_i is sampled on the system-clock edge at which sclk_o rises. The first 10 samples form data_o, MSB first. Samples 11 and 12 form sub_o, with sub_o[1] taken first. Samples 13 to 16 have no effect on any output.
- R7: With SPLIT_READ=1, the 8th and 9th rising edges of sclk_o are spaced 2*T_SCLK_HALF+T_GAP cycles apart, with sclk_o low in between. All other consecutive rising edges are spaced 2*T_SCLK_HALF apart.
- R8: done_o is high for exactly one cycle per conversion, no earlier than the last fall of sclk_o. data_o, sub_o and data_ext_o are valid in that cycle and hold their values until the next done_o.
- R9: data_ext_o is data_o sign-extended from bit 9 when the conversion used alt_i=1, and zero-extended when it used alt_i=0.
- R10: busy_o rises in the cycle after an accepted request and stays high through the done_o cycle. A request made while busy_o is high is ignored and adds no pulse on cnv_o.
- R11: A request held high through done_o is taken only in the cycle after done_o. cnv_o and busy_o are both low in that cycle, and cnv_o rises in the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken when idle |
| alt_i | input | 1 | Selection: 0 primary input or unipolar, 1 alternate input or bipolar |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Conversion-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result valid strobe |
| data_o | output | 10 | Raw conversion result |
| sub_o | output | 2 | Trailing sub-bits |
| data_ext_o | output | EXT_W (16) | Result widened by sign or zero extension |

## Verification
The result strobe and a new start request can fall in the same cycle. The request must lose in that cycle, so the converter is never restarted before its word has been read out in full. The bench holds the request high through a whole conversion and samples the cycle after done_o, where cnv_o and busy_o must both be low, and the cycle after that, where cnv_o must have risen. A second case puts a request in the middle of a conversion and counts cnv_o edges, so that any pulse the request sneaks in is seen as an extra edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_BITS = 10;
    localparam int SUB_BITS = 2;
    localparam int FRAME_BITS = RES_BITS + SUB_BITS;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_ACQ,
        ST_CONV,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [RES_BITS-1:0] code;
        logic [SUB_BITS-1:0] sub;
    } frame_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int T_PHASE     = 4,
    parameter int T_ACQ       = 150,
    parameter int T_CONV      = 380,
    parameter int T_SCLK_HALF = 7,
    parameter int T_GAP       = 16,
    parameter int READ_CLKS   = 16,
    parameter bit SPLIT_READ  = 1'b0,
    localparam int IDX_W      = $clog2(READ_CLKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             alt_i,
    output logic             cnv_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             alt_q_o,
    output logic             clear_o,
    output logic             sample_o,
    output logic             latch_o,
    output logic [IDX_W-1:0] bit_idx_o
);

    localparam int MAXT  = imax(imax(imax(T_PHASE, T_ACQ), imax(T_CONV, T_SCLK_HALF)), imax(T_GAP, 1));
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(READ_CLKS - 1);
    localparam logic [IDX_W-1:0] MID_IDX  = IDX_W'(READ_CLKS / 2 - 1);

    seq_state_e       state, state_n;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] bit_q;
    logic             t_end;
    logic             accept;

    function automatic logic [CNT_W-1:0] phase_len(input seq_state_e s);
        case (s)
            ST_PRE_HI, ST_PRE_LO: return CNT_W'(T_PHASE - 1);
            ST_ACQ:               return CNT_W'(T_ACQ - 1);
            ST_CONV:              return CNT_W'(T_CONV - 1);
            ST_CLK_LO, ST_CLK_HI: return CNT_W'(T_SCLK_HALF - 1);
            ST_GAP:               return CNT_W'(T_GAP - 1);
            default:              return '0;
        endcase
    endfunction

    assign t_end  = (cnt == '0);
    assign accept = (state == ST_IDLE) && start_i;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:   if (start_i) state_n = alt_i ? ST_PRE_HI : ST_ACQ;
            ST_PRE_HI: if (t_end) state_n = ST_PRE_LO;
            ST_PRE_LO: if (t_end) state_n = ST_ACQ;
            ST_ACQ:    if (t_end) state_n = ST_CONV;
            ST_CONV:   if (t_end) state_n = ST_CLK_LO;
            ST_CLK_LO: if (t_end) state_n = ST_CLK_HI;
            ST_CLK_HI: begin
                if (t_end) begin
                    if (bit_q == LAST_IDX)
                        state_n = ST_DONE;
                    else if (SPLIT_READ && bit_q == MID_IDX)
                        state_n = ST_GAP;
                    else
                        state_n = ST_CLK_LO;
                end
            end
            ST_GAP:    if (t_end) state_n = ST_CLK_LO;
            ST_DONE:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_q   <= '0;
            alt_q_o <= 1'b0;
            cnv_o   <= 1'b0;
            sclk_o  <= 1'b0;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            state <= state_n;
            if (state_n != state)
                cnt <= phase_len(state_n);
            else if (!t_end)
                cnt <= cnt - 1'b1;
            if (state_n == ST_CONV)
                bit_q <= '0;
            else if (state == ST_CLK_HI && state_n != ST_CLK_HI)
                bit_q <= bit_q + 1'b1;
            if (accept)
                alt_q_o <= alt_i;
            cnv_o  <= (state_n == ST_PRE_HI) || (state_n == ST_ACQ);
            sclk_o <= (state_n == ST_CLK_HI);
            busy_o <= (state_n != ST_IDLE);
            done_o <= (state_n == ST_DONE);
        end
    end

    assign clear_o   = accept;
    assign sample_o  = (state == ST_CLK_LO) && (state_n == ST_CLK_HI);
    assign latch_o   = (state != ST_DONE) && (state_n == ST_DONE);
    assign bit_idx_o = bit_q;

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
#(
    parameter int EXT_W     = 16,
    parameter int READ_CLKS = 16,
    localparam int IDX_W    = $clog2(READ_CLKS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_i,
    input  logic                sample_i,
    input  logic                latch_i,
    input  logic                alt_i,
    input  logic [IDX_W-1:0]    bit_idx_i,
    input  logic                sdo_i,
    output logic [RES_BITS-1:0] data_o,
    output logic [SUB_BITS-1:0] sub_o,
    output logic [EXT_W-1:0]    data_ext_o
);

    localparam int PAD_W = EXT_W - RES_BITS;

    logic [FRAME_BITS-1:0] shift_q;
    frame_t                frame;
    logic [EXT_W-1:0]      ext_n;

    assign frame = frame_t'(shift_q);
    assign ext_n = alt_i ? {{PAD_W{frame.code[RES_BITS-1]}}, frame.code}
                         : {{PAD_W{1'b0}}, frame.code};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q    <= '0;
            data_o     <= '0;
            sub_o      <= '0;
            data_ext_o <= '0;
        end else begin
            if (clear_i)
                shift_q <= '0;
            else if (sample_i && (32'(bit_idx_i) < FRAME_BITS))
                shift_q <= {shift_q[FRAME_BITS-2:0], sdo_i};
            if (latch_i) begin
                data_o     <= frame.code;
                sub_o      <= frame.sub;
                data_ext_o <= ext_n;
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int T_PHASE     = 4,
    parameter int T_ACQ       = 150,
    parameter int T_CONV      = 380,
    parameter int T_SCLK_HALF = 7,
    parameter int T_GAP       = 16,
    parameter bit SPLIT_READ  = 1'b0,
    parameter int EXT_W       = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                alt_i,
    input  logic                sdo_i,
    output logic                cnv_o,
    output logic                sclk_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] data_o,
    output logic [SUB_BITS-1:0] sub_o,
    output logic [EXT_W-1:0]    data_ext_o
);

    localparam int READ_CLKS = 16;
    localparam int IDX_W     = $clog2(READ_CLKS);

    logic             alt_q;
    logic             clear;
    logic             sample;
    logic             latch;
    logic [IDX_W-1:0] bit_idx;

    adc_seq_fsm #(
        .T_PHASE    (T_PHASE),
        .T_ACQ      (T_ACQ),
        .T_CONV     (T_CONV),
        .T_SCLK_HALF(T_SCLK_HALF),
        .T_GAP      (T_GAP),
        .READ_CLKS  (READ_CLKS),
        .SPLIT_READ (SPLIT_READ)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .alt_i    (alt_i),
        .cnv_o    (cnv_o),
        .sclk_o   (sclk_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .alt_q_o  (alt_q),
        .clear_o  (clear),
        .sample_o (sample),
        .latch_o  (latch),
        .bit_idx_o(bit_idx)
    );

    adc_seq_capture #(
        .EXT_W    (EXT_W),
        .READ_CLKS(READ_CLKS)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (clear),
        .sample_i  (sample),
        .latch_i   (latch),
        .alt_i     (alt_q),
        .bit_idx_i (bit_idx),
        .sdo_i     (sdo_i),
        .data_o    (data_o),
        .sub_o     (sub_o),
        .data_ext_o(data_ext_o)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int T_SCLK_HALF = 7,
    parameter int EXT_W       = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                cnv_o,
    input logic                sclk_o,
    input logic                busy_o,
    input logic                done_o,
    input logic [RES_BITS-1:0] data_o,
    input logic [EXT_W-1:0]    data_ext_o
);

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= '0;
        else if (sclk_o)
            hi_run <= hi_run + 1'b1;
        else
            hi_run <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!sclk_o && !cnv_o)); // R5

    AST_NO_CLK_IN_ACQ: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !cnv_o); // R4

    AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!sclk_o && $past(sclk_o)) |-> (32'(hi_run) >= T_SCLK_HALF)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(data_o)); // R8

    AST_EXT_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (data_ext_o[RES_BITS-1:0] == data_o)); // R9

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .T_SCLK_HALF(T_SCLK_HALF),
    .EXT_W      (EXT_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cnv_o     (cnv_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .data_o    (data_o),
    .data_ext_o(data_ext_o)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int P_PHASE = 2;
    localparam int P_ACQ   = 5;
    localparam int P_CONV  = 8;
    localparam int P_HALF  = 2;
    localparam int P_GAP   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        alt_i = 1'b0;
    logic        sdo_i;
    logic        cnv_o, sclk_o, busy_o, done_o;
    logic [9:0]  data_o;
    logic [1:0]  sub_o;
    logic [15:0] data_ext_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(
        .T_PHASE(P_PHASE), .T_ACQ(P_ACQ), .T_CONV(P_CONV),
        .T_SCLK_HALF(P_HALF), .T_GAP(P_GAP), .SPLIT_READ(1'b1), .EXT_W(16)
    ) i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .alt_i(alt_i), .sdo_i(sdo_i),
        .cnv_o(cnv_o), .sclk_o(sclk_o), .busy_o(busy_o), .done_o(done_o),
        .data_o(data_o), .sub_o(sub_o), .data_ext_o(data_ext_o)
    );

    // converter model: word presented after start falls, next bit after each clock fall
    logic [9:0]  m_code = '0;
    logic [1:0]  m_sub = '0;
    logic [15:0] m_word;
    int          m_idx = 16;
    logic        m_pcnv = 1'b0, m_psclk = 1'b0;

    assign m_word = {m_code, m_sub, 4'b1111};
    assign sdo_i  = (m_idx < 16) ? m_word[15 - m_idx] : 1'b1;

    always @(negedge clk) begin
        if (!cnv_o && m_pcnv) m_idx = 0;
        else if (!sclk_o && m_psclk) m_idx = m_idx + 1;
        m_pcnv  = cnv_o;
        m_psclk = sclk_o;
    end

    // monitor of output waveforms
    int cyc = 0;
    int n_cnv_r = 0, n_cnv_f = 0, n_sclk_r = 0, n_sclk_f = 0, n_done = 0;
    int cnv_r[4], cnv_f[4], sclk_r[20], sclk_f[20];
    int done_cyc = 0;
    logic p_cnv = 1'b0, p_sclk = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cnv_o && !p_cnv) begin if (n_cnv_r < 4) cnv_r[n_cnv_r] = cyc; n_cnv_r++; end
        if (!cnv_o && p_cnv) begin if (n_cnv_f < 4) cnv_f[n_cnv_f] = cyc; n_cnv_f++; end
        if (sclk_o && !p_sclk) begin if (n_sclk_r < 20) sclk_r[n_sclk_r] = cyc; n_sclk_r++; end
        if (!sclk_o && p_sclk) begin if (n_sclk_f < 20) sclk_f[n_sclk_f] = cyc; n_sclk_f++; end
        if (done_o) begin n_done++; done_cyc = cyc; end
        p_cnv  = cnv_o;
        p_sclk = sclk_o;
    end

    task automatic mon_clear();
        @(posedge clk);
        n_cnv_r = 0; n_cnv_f = 0; n_sclk_r = 0; n_sclk_f = 0; n_done = 0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 3000) begin @(negedge clk); n++; end
        chk(done_o, "R8 done_seen", int'(done_o), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!cnv_o && !sclk_o, "R1 lines_low", int'({cnv_o, sclk_o}), 0);
        chk(!busy_o && !done_o, "R1 status_low", int'({busy_o, done_o}), 0);
        chk(data_o == 0 && sub_o == 0 && data_ext_o == 0, "R1 result_zero", int'(data_ext_o), 0);
    endtask

    task automatic t_conv(input bit alt, input logic [9:0] code, input logic [1:0] sub);
        logic [15:0] exp_ext;
        m_code = code; m_sub = sub;
        mon_clear();
        @(negedge clk); start_i = 1'b1; alt_i = alt;
        @(negedge clk); start_i = 1'b0; alt_i = 1'b0;
        chk(busy_o, "R10 busy_after_start", int'(busy_o), 1);
        wait_done();
        chk(busy_o, "R10 busy_in_done", int'(busy_o), 1);
        chk(data_o == code, "R6 data", int'(data_o), int'(code));
        chk(sub_o == sub, "R6 sub", int'(sub_o), int'(sub));
        exp_ext = alt ? {{6{code[9]}}, code} : {6'b0, code};
        chk(data_ext_o == exp_ext, "R9 ext", int'(data_ext_o), int'(exp_ext));
        repeat (3) @(negedge clk);
        @(posedge clk);
        chk(data_o == code, "R8 held", int'(data_o), int'(code));
        chk(n_done == 1, "R8 one_strobe", n_done, 1);
        if (alt) begin
            chk(n_cnv_r == 2, "R3 two_pulses", n_cnv_r, 2);
            chk(cnv_f[0] - cnv_r[0] == P_PHASE, "R3 first_high", cnv_f[0] - cnv_r[0], P_PHASE);
            chk(cnv_r[1] - cnv_f[0] == P_PHASE, "R3 gap_low", cnv_r[1] - cnv_f[0], P_PHASE);
            chk(cnv_f[1] - cnv_r[1] == P_ACQ, "R3 acq_high", cnv_f[1] - cnv_r[1], P_ACQ);
        end else begin
            chk(n_cnv_r == 1, "R2 one_pulse", n_cnv_r, 1);
            chk(cnv_f[0] - cnv_r[0] == P_ACQ, "R2 acq_high", cnv_f[0] - cnv_r[0], P_ACQ);
        end
        chk(sclk_r[0] - cnv_f[n_cnv_f-1] >= P_CONV, "R4 conv_wait",
            sclk_r[0] - cnv_f[n_cnv_f-1], P_CONV);
        chk(n_sclk_r == 16, "R5 rise_count", n_sclk_r, 16);
        for (int k = 0; k < 16; k++) begin
            chk(sclk_f[k] - sclk_r[k] >= P_HALF, "R5 high_width", sclk_f[k] - sclk_r[k], P_HALF);
            if (k < 15)
                chk(sclk_r[k+1] - sclk_f[k] >= P_HALF, "R5 low_width", sclk_r[k+1] - sclk_f[k], P_HALF);
        end
        chk(sclk_r[8] - sclk_r[7] == 2*P_HALF + P_GAP, "R7 split_gap",
            sclk_r[8] - sclk_r[7], 2*P_HALF + P_GAP);
        chk(sclk_r[1] - sclk_r[0] == 2*P_HALF, "R7 normal_spacing", sclk_r[1] - sclk_r[0], 2*P_HALF);
        chk(done_cyc >= sclk_f[15], "R8 after_last_fall", done_cyc, sclk_f[15]);
        chk(!sclk_o && !busy_o, "R5 idle_low", int'({sclk_o, busy_o}), 0);
    endtask

    task automatic t_busy_ignore();
        m_code = 10'h2C3; m_sub = 2'b10;
        mon_clear();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        start_i = 1'b1; alt_i = 1'b1;
        @(negedge clk); start_i = 1'b0; alt_i = 1'b0;
        repeat (25) @(negedge clk);
        start_i = 1'b1; alt_i = 1'b1;
        @(negedge clk); start_i = 1'b0; alt_i = 1'b0;
        wait_done();
        chk(data_ext_o == 16'h02C3, "R10 mode_unchanged", int'(data_ext_o), 16'h02C3);
        repeat (12) @(negedge clk);
        @(posedge clk);
        chk(n_cnv_r == 1, "R10 ignored_request", n_cnv_r, 1);
        chk(!busy_o, "R10 busy_cleared", int'(busy_o), 0);
    endtask

    task automatic t_start_at_done();
        m_code = 10'h0F5; m_sub = 2'b01;
        mon_clear();
        @(negedge clk); start_i = 1'b1; alt_i = 1'b0;
        @(negedge clk);
        wait_done();
        @(negedge clk);
        chk(!busy_o && !cnv_o, "R11 gap_cycle", int'({busy_o, cnv_o}), 0);
        @(negedge clk);
        chk(cnv_o && busy_o, "R11 restart", int'({cnv_o, busy_o}), 3);
        start_i = 1'b0;
        wait_done();
        chk(data_o == 10'h0F5, "R11 second_result", int'(data_o), 10'h0F5);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_conv(1'b0, 10'h2A5, 2'b10);
        t_conv(1'b1, 10'h3F0, 2'b01);
        t_conv(1'b1, 10'h155, 2'b11);
        t_conv(1'b0, 10'h3FF, 2'b11);
        t_conv(1'b0, 10'h000, 2'b00);
        t_busy_ignore();
        t_start_at_done();
        finish_run();
    end

endmodule